// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches one 16-bit word from a serial EEPROM that talks over a chip-select, clock, data-out and data-in line set. A host pulses `start_i` for one cycle with a 6-bit word address on `addr_i`. The controller then raises chip select and clocks out a start bit, the two-bit read opcode and the address. It waits for the device to pull its data line low as an acknowledge, then clocks in sixteen data bits, most significant first. It ends with a one-cycle `done_o` strobe and the word on `word_o`.

The serial clock rate is set per transaction by `half_div_i`. Each high or low phase of the serial clock lasts `half_div_i + 1` system clock cycles. The acknowledge wait is bounded by `ack_limit_i`. A device that never answers ends the transaction with `err_o` set alongside `done_o`, and chip select is released. Both settings are captured when a start is accepted, so later changes do not disturb a frame in flight.

Top module: `sprom_word_reader`

## Requirements
- R1: After reset, chip select and serial clock are 0, data-out is 1, and `busy_o`, `done_o`, `err_o` and `word_o` are all 0.
- R2: A start pulse is accepted only while `busy_o` is 0. A start pulse during a transaction has no effect on the frame sent or on the result.
- R3: An accepted start raises chip select with the clock low and data-out at 1 for one phase. It then sends nine clock pulses carrying 1, 1, 0 and then address bits 5 down to 0. Data-out changes only at the system clock edge where the serial clock falls, and never while the serial clock is high.
- R4: Every high phase and every low phase of the serial clock lasts exactly `half_div_i + 1` system clock cycles, using the value captured at the accepted start.
- R5: After the low phase that follows the ninth pulse, the controller holds the clock low and data-out at 0. From the next cycle on, it samples data-in once per cycle and starts the data phase in the cycle after the first sample that reads 0.
- R6: The data phase gives sixteen clock pulses. Data-in is captured at the edge where each high phase ends, and the first captured bit lands in `word_o[15]`.
- R7: After the sixteenth low phase, chip select falls, data-out returns to 1 and `done_o` is 1 for exactly one cycle. `word_o` takes the new word in that cycle and holds it until the next successful read.
- R8: If `ack_limit_i` successive acknowledge samples all read 1 (a limit of 0 acts as 1), the transaction ends as in R7 but with `err_o` set during the `done_o` cycle. `word_o` keeps its previous value.
- R9: `busy_o` is 1 from the cycle after an accepted start until the `done_o` cycle, in which it is 0. While busy, chip select stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to read a word |
| addr_i | input | 6 | Word address, sampled with an accepted start |
| half_div_i | input | 8 | Serial clock phase length minus one, in system cycles |
| ack_limit_i | input | 16 | Maximum number of acknowledge samples before timeout |
| mem_miso_i | input | 1 | Data line from the EEPROM |
| mem_cs_o | output | 1 | Chip select to the EEPROM, active high |
| mem_clk_o | output | 1 | Serial clock to the EEPROM |
| mem_mosi_o | output | 1 | Data line to the EEPROM |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction strobe |
| err_o | output | 1 | Acknowledge timeout, valid with `done_o` |
| word_o | output | 16 | Last word read successfully |

## Verification
The bench compares the serial lines and the status outputs with a queue-driven reference on every cycle. It covers the fastest divider setting, where an off-by-one in phase length would shift every edge, and a divider change in mid-frame, which a design that fails to capture the value would follow. Acknowledge timing is probed with an immediate answer, a late answer and no answer under limits of 5 and 0. An early or late timeout, or a word clobbered on error, shows up as a mismatch on `err_o` or `word_o`. A second start with a different address during a busy frame catches a controller that restarts or takes the new address. Data patterns with set bits at both ends catch a bit-order or first-sample slip.

// File: rtl/sprom_pkg.sv
// Shared definitions for the serial EEPROM word reader.
// Assumes a read frame prefix of start bit plus a two-bit opcode.
package sprom_pkg;

    // Controller sequencing states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CMD,
        ST_ACK,
        ST_DATA
    } sprom_state_e;

    // Start bit followed by the read opcode, sent first on the wire
    localparam int unsigned PREFIX_W = 3;
    localparam logic [PREFIX_W-1:0] RD_PREFIX = 3'b110;

endpackage

// File: rtl/sprom_phase_timer.sv
// Phase timer: marks the last system cycle of each serial clock phase.
// Captures the divider on load so that a frame keeps one rate throughout.
// Assumes the counter sits at zero whenever run is low between phases.
module sprom_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             phase_end_o
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;

    // Phase ends once the counter has reached the captured divider
    assign phase_end_o = run_i && (cnt_q == div_q);

    // Capture divider at start, then count cycles within each phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (load_i) begin
            div_q <= div_i;
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= phase_end_o ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sprom_rx_shift.sv
// Receive path: shifts data-in bits in MSB first and publishes the word.
// Assumes exactly DATA_W samples arrive before each commit.
module sprom_rx_shift #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_i,
    input  logic              bit_i,
    input  logic              commit_i,
    output logic [DATA_W-1:0] word_o
);

    logic [DATA_W-1:0] shreg_q;
    logic [DATA_W-1:0] word_q;

    assign word_o = word_q;

    // Collect bits; the earliest sample ends up in the top bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (sample_i) begin
            shreg_q <= {shreg_q[DATA_W-2:0], bit_i};
        end
    end

    // Publish the assembled word only on a successful finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (commit_i) begin
            word_q <= shreg_q;
        end
    end

endmodule

// File: rtl/sprom_ctrl.sv
// Frame sequencer: drives chip select, serial clock and data-out through
// setup, command/address, acknowledge wait and data phases.
// Assumes the phase timer pulses phase_end_i only while run_o is high.
module sprom_ctrl
    import sprom_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int LIM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LIM_W-1:0]  ack_limit_i,
    input  logic              miso_i,
    input  logic              phase_end_i,
    output logic              load_o,
    output logic              run_o,
    output logic              sample_o,
    output logic              commit_o,
    output logic              cs_o,
    output logic              sk_o,
    output logic              mosi_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);

    localparam int TX_W  = PREFIX_W + ADDR_W;
    localparam int MAXB  = (TX_W > DATA_W) ? TX_W : DATA_W;
    localparam int CNT_W = $clog2(MAXB + 1);
    localparam logic [CNT_W-1:0] TX_END  = CNT_W'(TX_W);
    localparam logic [CNT_W-1:0] TX_LAST = CNT_W'(TX_W - 1);
    localparam logic [CNT_W-1:0] RX_END  = CNT_W'(DATA_W);

    sprom_state_e      st_q;
    logic [TX_W-1:0]   tx_q;
    logic [CNT_W-1:0]  bcnt_q;
    logic [LIM_W-1:0]  acnt_q;
    logic [LIM_W-1:0]  lim_q;
    logic              cs_q, sk_q, mosi_q, done_q, err_q;
    logic [TX_W-1:0]   frame_w;
    logic [LIM_W:0]    acnt_next;
    logic              ack_expired;

    assign frame_w     = {RD_PREFIX, addr_i};
    assign acnt_next   = {1'b0, acnt_q} + {{LIM_W{1'b0}}, 1'b1};
    assign ack_expired = acnt_next >= {1'b0, lim_q};

    // Handshake strobes to the timer and the receive path
    assign load_o   = (st_q == ST_IDLE) && start_i;
    assign run_o    = (st_q == ST_SETUP) || (st_q == ST_CMD) || (st_q == ST_DATA);
    assign sample_o = (st_q == ST_DATA) && phase_end_i && sk_q;
    assign commit_o = (st_q == ST_DATA) && phase_end_i && !sk_q && (bcnt_q == RX_END);

    assign cs_o   = cs_q;
    assign sk_o   = sk_q;
    assign mosi_o = mosi_q;
    assign busy_o = (st_q != ST_IDLE);
    assign done_o = done_q;
    assign err_o  = err_q;

    // Main sequencer: advances the frame at each phase boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            tx_q   <= '0;
            bcnt_q <= '0;
            acnt_q <= '0;
            lim_q  <= '0;
            cs_q   <= 1'b0;
            sk_q   <= 1'b0;
            mosi_q <= 1'b1;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        st_q   <= ST_SETUP;
                        cs_q   <= 1'b1;
                        sk_q   <= 1'b0;
                        mosi_q <= frame_w[TX_W-1];
                        tx_q   <= frame_w << 1;
                        bcnt_q <= '0;
                        lim_q  <= ack_limit_i;
                    end
                end
                ST_SETUP: begin
                    if (phase_end_i) begin
                        st_q <= ST_CMD;
                        sk_q <= 1'b1;
                    end
                end
                ST_CMD: begin
                    if (phase_end_i) begin
                        if (sk_q) begin
                            sk_q   <= 1'b0;
                            mosi_q <= (bcnt_q == TX_LAST) ? 1'b0 : tx_q[TX_W-1];
                            tx_q   <= tx_q << 1;
                            bcnt_q <= bcnt_q + 1'b1;
                        end else if (bcnt_q == TX_END) begin
                            st_q   <= ST_ACK;
                            acnt_q <= '0;
                        end else begin
                            sk_q <= 1'b1;
                        end
                    end
                end
                ST_ACK: begin
                    if (!miso_i) begin
                        st_q   <= ST_DATA;
                        sk_q   <= 1'b1;
                        bcnt_q <= '0;
                    end else if (ack_expired) begin
                        st_q   <= ST_IDLE;
                        cs_q   <= 1'b0;
                        mosi_q <= 1'b1;
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                    end else begin
                        acnt_q <= acnt_next[LIM_W-1:0];
                    end
                end
                ST_DATA: begin
                    if (phase_end_i) begin
                        if (sk_q) begin
                            sk_q   <= 1'b0;
                            bcnt_q <= bcnt_q + 1'b1;
                        end else if (bcnt_q == RX_END) begin
                            st_q   <= ST_IDLE;
                            cs_q   <= 1'b0;
                            mosi_q <= 1'b1;
                            done_q <= 1'b1;
                        end else begin
                            sk_q <= 1'b1;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sprom_word_reader.sv
// Top level of the serial EEPROM word reader.
// Joins the phase timer, the frame sequencer and the receive shifter.
// Assumes mem_miso_i is already synchronous to clk.
module sprom_word_reader #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int DIV_W  = 8,
    parameter int LIM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DIV_W-1:0]  half_div_i,
    input  logic [LIM_W-1:0]  ack_limit_i,
    input  logic              mem_miso_i,
    output logic              mem_cs_o,
    output logic              mem_clk_o,
    output logic              mem_mosi_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [DATA_W-1:0] word_o
);

    logic load_w, run_w, phase_end_w, sample_w, commit_w;

    sprom_phase_timer #(
        .DIV_W (DIV_W)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_w),
        .run_i       (run_w),
        .div_i       (half_div_i),
        .phase_end_o (phase_end_w)
    );

    sprom_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LIM_W  (LIM_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .addr_i      (addr_i),
        .ack_limit_i (ack_limit_i),
        .miso_i      (mem_miso_i),
        .phase_end_i (phase_end_w),
        .load_o      (load_w),
        .run_o       (run_w),
        .sample_o    (sample_w),
        .commit_o    (commit_w),
        .cs_o        (mem_cs_o),
        .sk_o        (mem_clk_o),
        .mosi_o      (mem_mosi_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .err_o       (err_o)
    );

    sprom_rx_shift #(
        .DATA_W (DATA_W)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample_w),
        .bit_i    (mem_miso_i),
        .commit_i (commit_w),
        .word_o   (word_o)
    );

endmodule

// File: rtl/sprom_word_reader_chk.sv
// Protocol checker for the word reader, attached by bind below.
// Watches only the top-level ports.
module sprom_word_reader_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_cs_o,
    input logic              mem_clk_o,
    input logic              mem_mosi_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic [DATA_W-1:0] word_o
);

    // R1: idle line levels whenever no transaction runs
    a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_cs_o && !mem_clk_o && mem_mosi_o))
        else $error("a_r1_idle_lines");

    // R3: data-out never moves while the serial clock is high
    a_r3_mosi_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
        mem_clk_o |-> $stable(mem_mosi_o))
        else $error("a_r3_mosi_clk_low");

    // R4: serial clock only toggles inside a selected frame
    a_r4_clk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        mem_clk_o |-> mem_cs_o)
        else $error("a_r4_clk_needs_cs");

    // R7: done is a single-cycle strobe
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o)
        else $error("a_r7_done_pulse");

    // R7: the result changes only together with done
    a_r7_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(word_o))
        else $error("a_r7_word_stable");

    // R8: error is reported only with done
    a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o)
        else $error("a_r8_err_with_done");

    // R9: done closes a busy period
    a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)))
        else $error("a_r9_done_ends_busy");

    // R9: chip select held for the whole transaction
    a_r9_busy_cs: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> mem_cs_o)
        else $error("a_r9_busy_cs");

endmodule

bind sprom_word_reader sprom_word_reader_chk #(
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_cs_o   (mem_cs_o),
    .mem_clk_o  (mem_clk_o),
    .mem_mosi_o (mem_mosi_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .word_o     (word_o)
);

// File: tb/tb_sprom_word_reader.sv
// Bench: queue-based reference of the expected wire levels, compared on
// every cycle, plus a behavioural EEPROM that answers read frames.
module tb_sprom_word_reader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [5:0]  addr_i = '0;
    logic [7:0]  half_div_i = '0;
    logic [15:0] ack_limit_i = 16'd20;
    logic        miso = 1'b1;
    logic        cs, sk, mosi, busy, done, err;
    logic [15:0] word;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    sprom_word_reader dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .addr_i      (addr_i),
        .half_div_i  (half_div_i),
        .ack_limit_i (ack_limit_i),
        .mem_miso_i  (miso),
        .mem_cs_o    (cs),
        .mem_clk_o   (sk),
        .mem_mosi_o  (mosi),
        .busy_o      (busy),
        .done_o      (done),
        .err_o       (err),
        .word_o      (word)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural EEPROM ----------------
    logic [15:0] dev_word = '0;
    int          dev_delay = 0;
    int          dev_n = 0, dev_bit = 0, dev_wait = 0;
    bit          dev_acked = 0, prev_sk = 0;
    logic [8:0]  dev_rx = '0, dev_frame = '0;

    // Device reacts to wire levels at the falling system clock edge
    always @(negedge clk) begin
        if (!cs) begin
            dev_n = 0; dev_bit = 0; dev_wait = 0; dev_acked = 0; miso = 1'b1;
        end else begin
            if (sk && !prev_sk) begin
                if (dev_n < 9) begin
                    dev_rx = {dev_rx[7:0], mosi};
                    dev_n++;
                    if (dev_n == 9) dev_frame = dev_rx;
                end else if (dev_acked && dev_bit < 16) begin
                    miso = dev_word[15 - dev_bit];
                    dev_bit++;
                end
            end
            if (dev_n == 9 && !dev_acked && !sk) begin
                if (dev_wait >= dev_delay) begin
                    miso = 1'b0; dev_acked = 1;
                end else dev_wait++;
            end
        end
        prev_sk = sk;
    end

    // ---------------- reference model ----------------
    logic [2:0]  q[$];
    int          mode = 0, ph = 1, acnt = 0, lim = 0;
    logic        e_cs = 0, e_sk = 0, e_mosi = 1, e_busy = 0, e_done = 0, e_err = 0;
    logic [15:0] e_word = '0;

    task automatic pop_exp();
        logic [2:0] e;
        e = q.pop_front();
        e_cs = e[2]; e_sk = e[1]; e_mosi = e[0];
    endtask

    task automatic finish_exp(input bit is_err);
        mode = 0; e_cs = 0; e_sk = 0; e_mosi = 1; e_busy = 0;
        e_done = 1; e_err = is_err;
        if (!is_err) e_word = dev_word;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); mode = 0;
            e_cs = 0; e_sk = 0; e_mosi = 1; e_busy = 0; e_done = 0; e_err = 0; e_word = '0;
        end else begin
            e_done = 0; e_err = 0;
            case (mode)
                0: if (start_i) begin
                    logic [8:0] fb;
                    fb = {3'b110, addr_i};
                    ph = int'(half_div_i) + 1;
                    lim = int'(ack_limit_i);
                    for (int i = 0; i < ph; i++) q.push_back({1'b1, 1'b0, 1'b1});
                    for (int k = 0; k < 9; k++) begin
                        for (int i = 0; i < ph; i++) q.push_back({1'b1, 1'b1, fb[8-k]});
                        for (int i = 0; i < ph; i++)
                            q.push_back({1'b1, 1'b0, (k < 8) ? fb[7-k] : 1'b0});
                    end
                    pop_exp(); mode = 1; e_busy = 1;
                end
                1: if (q.size() == 0) begin
                    mode = 2; acnt = 0; e_cs = 1; e_sk = 0; e_mosi = 0;
                end else pop_exp();
                2: if (!miso) begin
                    for (int k = 0; k < 16; k++) begin
                        for (int i = 0; i < ph; i++) q.push_back(3'b110);
                        for (int i = 0; i < ph; i++) q.push_back(3'b100);
                    end
                    pop_exp(); mode = 3;
                end else if (acnt + 1 >= lim) finish_exp(1'b1);
                else acnt++;
                default: if (q.size() == 0) finish_exp(1'b0); else pop_exp();
            endcase
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(cs == e_cs, (mode == 2) ? "R5 cs" : "R3 cs", cs, e_cs);
            chk(sk == e_sk, "R4 sk", sk, e_sk);
            chk(mosi == e_mosi, (mode == 2) ? "R5 mosi" : "R3 mosi", mosi, e_mosi);
            chk(busy == e_busy, "R9 busy", busy, e_busy);
            chk(done == e_done, "R7 done", done, e_done);
            chk(err == e_err, "R8 err", err, e_err);
            chk(word == e_word, "R7 word", word, e_word);
        end
    end

    // ---------------- stimulus ----------------
    task automatic pulse_start(input logic [5:0] a);
        @(negedge clk);
        start_i = 1'b1; addr_i = a;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic run_read(input logic [5:0] a, input logic [15:0] w,
                            input logic [7:0] hd, input int dly, input logic [15:0] lim_v);
        dev_word = w; dev_delay = dly; half_div_i = hd; ack_limit_i = lim_v;
        pulse_start(a);
        wait_done();
        chk(err == 1'b0, "R8 no error", err, 0);
        chk(word == w, "R6 word", word, w);
        chk(dev_frame == {3'b110, a}, "R3 frame", dev_frame, {3'b110, a});
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(cs == 0, "R1 cs", cs, 0);
        chk(sk == 0, "R1 sk", sk, 0);
        chk(mosi == 1, "R1 mosi", mosi, 1);
        chk(busy == 0 && done == 0 && err == 0, "R1 status", {busy, done, err}, 0);
        chk(word == 0, "R1 word", word, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R6: fastest clock, immediate acknowledge
        run_read(6'h2A, 16'hA5C3, 8'd0, 0, 16'd20);
        run_read(6'h3F, 16'h8001, 8'd1, 2, 16'd20);
        run_read(6'h00, 16'hFFFF, 8'd0, 0, 16'd1);

        // R2: second start with another address while busy is ignored
        dev_word = 16'h5A3C; dev_delay = 4; half_div_i = 8'd2; ack_limit_i = 16'd20;
        pulse_start(6'h15);
        repeat (10) @(negedge clk);
        pulse_start(6'h3F);
        wait_done();
        chk(dev_frame == {3'b110, 6'h15}, "R2 frame kept", dev_frame, {3'b110, 6'h15});
        chk(word == 16'h5A3C, "R2 word", word, 16'h5A3C);
        @(negedge clk);

        // R4: divider changed mid-frame must not alter the phase length
        dev_word = 16'h0F0F; dev_delay = 1; half_div_i = 8'd1;
        pulse_start(6'h09);
        repeat (7) @(negedge clk);
        half_div_i = 8'd5;
        wait_done();
        chk(word == 16'h0F0F, "R4 word", word, 16'h0F0F);
        @(negedge clk);

        // R8: no acknowledge, limit 5, word kept
        dev_word = 16'h1234; dev_delay = 100000; half_div_i = 8'd0; ack_limit_i = 16'd5;
        pulse_start(6'h11);
        wait_done();
        chk(err == 1'b1, "R8 timeout err", err, 1);
        chk(word == 16'h0F0F, "R8 word held", word, 16'h0F0F);
        chk(cs == 1'b0, "R8 cs released", cs, 0);
        @(negedge clk);

        // R8: limit 0 behaves as 1
        ack_limit_i = 16'd0;
        pulse_start(6'h22);
        wait_done();
        chk(err == 1'b1, "R8 zero limit err", err, 1);
        @(negedge clk);

        // R5: late answer within the limit
        run_read(6'h1C, 16'hC3A5, 8'd0, 6, 16'd10);

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog expired actual=%0d expected=0", busy);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule